// File: doc/BRIEF.md
# FP Pipeline Issue Hazard Checker

This block is the decode-stage issue gate of an in-order pipeline whose execute side has an integer path, a fully pipelined floating-point adder, a fully pipelined floating-point/integer multiplier and an iterative divider. Each cycle the decoder presents one instruction: the kind of unit it goes to, an optional destination register and up to two source registers. The block answers in the same cycle with `issue` or with one or more stall reasons. An instruction that issues is never held later, so every hazard is settled here.

In-flight results are kept in a timing wheel that has one slot per cycle until register-file writeback. The slot number at which an entry sits gives its remaining latency, its writeback cycle and, for the long units, the execute stage it occupies. The same wheel serves as the write-port reservation vector. A separate countdown keeps the divider from accepting work while it iterates. Stalled instructions are rechecked each cycle until every reason has cleared.

Top module: `fp_issue_hazard`

## Requirements
- R1: When `id_valid` is low, `issue` and all stall flags are low, and nothing is recorded. An idle decode stage leaves no trace on later instructions.
- R2: Unit codes are 0 integer, 1 load/store, 2 FP add, 3 FP multiply and 4 FP divide. A consumer of a result may issue no earlier than producer issue + 1 + latency, with latencies 0 integer, 1 load, 3 add, 6 multiply and 24 divide. Until then `stall_raw` is high. A producer one cycle older (integer) or two cycles older (load) is forwarded without a stall.
- R3: A register tag is 6 bits. Bit 5 selects the FP file (1) or the integer file (0), and bits 4:0 give the index. Only equal tags count as a dependence, so R5 and F5 never interact.
- R4: An issued instruction that has a destination writes back at issue + execute stages + 2 (cycle 3 for integer and load, 6 for add, 9 for multiply, 27 for divide). A new instruction whose writeback cycle is already reserved raises `stall_port` and is rechecked in the next cycle.
- R5: After a divide issues, no divide may issue for the next 24 cycles. A divide presented in that window raises `stall_div`.
- R6: `stall_waw` is high while an add, multiply or divide with the same destination tag is still at least two cycles from writeback.
- R7: The adder and multiplier accept independent operations on consecutive cycles with no structural stall.
- R8: `issue` is high exactly when `id_valid` is high and no stall flag is high. Several stall flags may be high together.
- R9: Reset clears all in-flight state and the divider countdown, so the first instruction after reset issues at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_unit | input | 3 | Unit code (R2) |
| id_dst_en | input | 1 | Instruction writes a register |
| id_dst | input | 6 | Destination tag (R3) |
| id_src_en | input | 2 | Source enables, bit 0 for A and bit 1 for B |
| id_src_a | input | 6 | First source tag |
| id_src_b | input | 6 | Second source tag |
| issue | output | 1 | Instruction leaves decode at this edge |
| stall_raw | output | 1 | Source operand not ready |
| stall_waw | output | 1 | Destination pending in a long unit |
| stall_div | output | 1 | Divider still iterating |
| stall_port | output | 1 | Writeback cycle already reserved |

## Verification
The main pattern is a mixed FP instruction stream: load feeding multiply feeding add feeding store, followed by back-to-back divides, an add that reuses a divide's destination, and a burst of short instructions that land on writeback cycles already taken. For each instruction the bench compares the number of stalled cycles, and the flags seen in the first stalled cycle, against hand-derived timing. This separates latency errors (RAW counts off by one) from port, divider and WAW errors. An integer register that shares an index with a pending FP register shows that the two register files are kept apart. Directed cases cover idle decode, the divider window and reset in the middle of a divide.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [2:0] {
      UNIT_INT  = 3'd0,
      UNIT_MEM  = 3'd1,
      UNIT_FADD = 3'd2,
      UNIT_FMUL = 3'd3,
      UNIT_FDIV = 3'd4
   } unit_e;

   // Cycles from the end of execute to writeback: one memory stage plus one.
   localparam int WB_GAP = 2;

endpackage

// File: rtl/hz_div_busy.sv
module hz_div_busy #(
   parameter int II = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (II > 1) ? $clog2(II) + 1 : 1;

   generate
      if (II < 1) begin : g_bad
         $error("hz_div_busy: II must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(II - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/hz_wb_wheel.sv
module hz_wb_wheel #(
   parameter  int TAG_W  = 6,
   parameter  int DEPTH  = 28,
   localparam int SLOT_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_long,
   input  logic              wr_load,
   input  logic [SLOT_W-1:0] q_slot,
   input  logic              q_dst_en,
   input  logic [TAG_W-1:0]  q_dst,
   input  logic [1:0]        q_src_en,
   input  logic [TAG_W-1:0]  q_src_a,
   input  logic [TAG_W-1:0]  q_src_b,
   output logic              port_busy,
   output logic              raw_hit,
   output logic              waw_hit
);
   // Slot j holds the instruction that writes back j cycles from now.
   typedef struct packed {
      logic             v;
      logic             lng;
      logic             ld;
      logic [TAG_W-1:0] tag;
   } ent_t;

   generate
      if (DEPTH < 4) begin : g_bad
         $error("hz_wb_wheel: DEPTH too small");
      end
   endgenerate

   ent_t             slot_q [DEPTH];
   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] raw_v;
   logic [DEPTH-1:0] waw_v;
   ent_t             new_e;

   assign new_e = '{v: 1'b1, lng: wr_long, ld: wr_load, tag: wr_tag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
      end else begin
         for (int j = 0; j < DEPTH; j++) begin
            if (wr_en && (wr_slot == SLOT_W'(j)))
               slot_q[j] <= new_e;
            else if (j < DEPTH - 1)
               slot_q[j] <= slot_q[(j < DEPTH - 1) ? j + 1 : j];
            else
               slot_q[j] <= '0;
         end
      end
   end

   generate
      for (genvar j = 0; j < DEPTH; j++) begin : g_slot
         logic src_m;
         logic late;
         assign src_m = (q_src_en[0] && (slot_q[j].tag == q_src_a)) ||
                        (q_src_en[1] && (slot_q[j].tag == q_src_b));
         // Loads forward from memory one cycle before writeback,
         // execute results two cycles before.
         assign late     = slot_q[j].ld ? (j > 1) : (j > 2);
         assign vld[j]   = slot_q[j].v;
         assign raw_v[j] = slot_q[j].v && src_m && late;
         assign waw_v[j] = slot_q[j].v && slot_q[j].lng && q_dst_en &&
                           (slot_q[j].tag == q_dst) && (j >= 2);
      end
   endgenerate

   assign port_busy = vld[q_slot];
   assign raw_hit   = |raw_v;
   assign waw_hit   = |waw_v;

endmodule

// File: rtl/fp_issue_hazard.sv
module fp_issue_hazard #(
   parameter int REG_IDX_W     = 5,
   parameter int INT_STAGES    = 1,
   parameter int FADD_STAGES   = 4,
   parameter int FMUL_STAGES   = 7,
   parameter int FDIV_STAGES   = 25,
   parameter bit DIV_PIPELINED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 id_valid,
   input  logic [2:0]           id_unit,
   input  logic                 id_dst_en,
   input  logic [REG_IDX_W:0]   id_dst,
   input  logic [1:0]           id_src_en,
   input  logic [REG_IDX_W:0]   id_src_a,
   input  logic [REG_IDX_W:0]   id_src_b,
   output logic                 issue,
   output logic                 stall_raw,
   output logic                 stall_waw,
   output logic                 stall_div,
   output logic                 stall_port
);
   import hz_pkg::*;

   localparam int TAG_W    = REG_IDX_W + 1;
   localparam int OFF_INT  = INT_STAGES + WB_GAP;
   localparam int OFF_FADD = FADD_STAGES + WB_GAP;
   localparam int OFF_FMUL = FMUL_STAGES + WB_GAP;
   localparam int OFF_FDIV = FDIV_STAGES + WB_GAP;
   localparam int MAX_AM   = (OFF_FADD > OFF_FMUL) ? OFF_FADD : OFF_FMUL;
   localparam int MAX_AMD  = (MAX_AM > OFF_FDIV) ? MAX_AM : OFF_FDIV;
   localparam int WB_MAX   = (MAX_AMD > OFF_INT) ? MAX_AMD : OFF_INT;
   localparam int DEPTH    = WB_MAX + 1;
   localparam int SLOT_W   = $clog2(DEPTH);
   localparam int DIV_II   = DIV_PIPELINED ? 1 : FDIV_STAGES;

   generate
      if (REG_IDX_W < 1 || INT_STAGES < 1 || FADD_STAGES < 1 ||
          FMUL_STAGES < 1 || FDIV_STAGES < 1) begin : g_bad
         $error("fp_issue_hazard: widths and stage counts must be positive");
      end
   endgenerate

   logic [SLOT_W-1:0] wb_off;
   logic              is_long;
   logic              is_load;
   logic              port_busy;
   logic              raw_hit;
   logic              waw_hit;
   logic              div_busy;
   logic              div_start;

   always_comb begin
      wb_off  = SLOT_W'(OFF_INT);
      is_long = 1'b0;
      is_load = 1'b0;
      case (id_unit)
         UNIT_MEM:  is_load = id_dst_en;
         UNIT_FADD: begin wb_off = SLOT_W'(OFF_FADD); is_long = 1'b1; end
         UNIT_FMUL: begin wb_off = SLOT_W'(OFF_FMUL); is_long = 1'b1; end
         UNIT_FDIV: begin wb_off = SLOT_W'(OFF_FDIV); is_long = 1'b1; end
         default: ;
      endcase
   end

   hz_wb_wheel #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_wheel (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (issue && id_dst_en),
      .wr_slot   (wb_off - SLOT_W'(1)),
      .wr_tag    (id_dst),
      .wr_long   (is_long),
      .wr_load   (is_load),
      .q_slot    (wb_off),
      .q_dst_en  (id_dst_en),
      .q_dst     (id_dst),
      .q_src_en  (id_src_en),
      .q_src_a   (id_src_a),
      .q_src_b   (id_src_b),
      .port_busy (port_busy),
      .raw_hit   (raw_hit),
      .waw_hit   (waw_hit)
   );

   assign div_start = issue && (id_unit == UNIT_FDIV);

   generate
      if (DIV_PIPELINED) begin : g_div_pipe
         assign div_busy = 1'b0;
      end else begin : g_div_iter
         hz_div_busy #(.II(DIV_II)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .busy  (div_busy)
         );
      end
   endgenerate

   assign stall_raw  = id_valid && raw_hit;
   assign stall_waw  = id_valid && waw_hit;
   assign stall_port = id_valid && id_dst_en && port_busy;
   assign stall_div  = id_valid && (id_unit == UNIT_FDIV) && div_busy;
   assign issue      = id_valid && !(raw_hit || waw_hit ||
                                     (id_dst_en && port_busy) ||
                                     ((id_unit == UNIT_FDIV) && div_busy));

endmodule

// File: rtl/fp_issue_hazard_chk.sv
module fp_issue_hazard_chk #(
   parameter int DIV_II = 25
) (
   input logic       clk,
   input logic       rst_n,
   input logic       id_valid,
   input logic [2:0] id_unit,
   input logic       id_dst_en,
   input logic [1:0] id_src_en,
   input logic       issue,
   input logic       stall_raw,
   input logic       stall_waw,
   input logic       stall_div,
   input logic       stall_port
);
   localparam int SW = $clog2(DIV_II + 1) + 1;

   logic [SW-1:0] since_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_div <= SW'(DIV_II);
      else if (issue && (id_unit == hz_pkg::UNIT_FDIV))
         since_div <= SW'(1);
      else if (since_div < SW'(DIV_II))
         since_div <= since_div + SW'(1);
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid |-> !(issue || stall_raw || stall_waw || stall_div || stall_port));

   a_r8_issue_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !(stall_raw || stall_waw || stall_div || stall_port));

   a_r5_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (id_unit == hz_pkg::UNIT_FDIV)) |-> (since_div >= SW'(DIV_II)));

   a_r5_div_flag_unit: assert property (@(posedge clk) disable iff (!rst_n)
      stall_div |-> (id_unit == hz_pkg::UNIT_FDIV));

   a_r2_raw_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      stall_raw |-> (id_src_en != 2'b00));

   a_r6_waw_needs_dest: assert property (@(posedge clk) disable iff (!rst_n)
      stall_waw |-> id_dst_en);

   a_r4_port_needs_dest: assert property (@(posedge clk) disable iff (!rst_n)
      stall_port |-> id_dst_en);

endmodule

bind fp_issue_hazard fp_issue_hazard_chk #(.DIV_II(DIV_II)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .id_valid   (id_valid),
   .id_unit    (id_unit),
   .id_dst_en  (id_dst_en),
   .id_src_en  (id_src_en),
   .issue      (issue),
   .stall_raw  (stall_raw),
   .stall_waw  (stall_waw),
   .stall_div  (stall_div),
   .stall_port (stall_port)
);

// File: tb/fp_issue_hazard_test.sv
module fp_issue_hazard_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       id_valid = 1'b0;
   logic [2:0] id_unit = '0;
   logic       id_dst_en = 1'b0;
   logic [5:0] id_dst = '0;
   logic [1:0] id_src_en = '0;
   logic [5:0] id_src_a = '0;
   logic [5:0] id_src_b = '0;
   logic       issue, stall_raw, stall_waw, stall_div, stall_port;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_issue_hazard uut (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
      .id_dst_en(id_dst_en), .id_dst(id_dst), .id_src_en(id_src_en),
      .id_src_a(id_src_a), .id_src_b(id_src_b), .issue(issue),
      .stall_raw(stall_raw), .stall_waw(stall_waw), .stall_div(stall_div),
      .stall_port(stall_port)
   );

   // flag vector order: {port, div, waw, raw}
   typedef struct packed {
      logic [2:0] unit;
      logic       den;
      logic [5:0] dst;
      logic [1:0] sen;
      logic [5:0] sa;
      logic [5:0] sb;
      logic [7:0] stl;
      logic [3:0] flg;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 17;
   // Tags: FP register n = 32 + n, integer register n = n (R3).
   localparam vec_t TBL [NV] = '{
      '{3'd1, 1'b1, 6'd36, 2'b01, 6'd2,  6'd0,  8'd0,  4'b0000, 4'd2}, // R2 load F4
      '{3'd3, 1'b1, 6'd32, 2'b11, 6'd36, 6'd38, 8'd1,  4'b0001, 4'd2}, // R2 mul uses load
      '{3'd2, 1'b1, 6'd34, 2'b11, 6'd32, 6'd40, 8'd6,  4'b0001, 4'd2}, // R2 add uses mul
      '{3'd1, 1'b0, 6'd0,  2'b11, 6'd2,  6'd34, 8'd3,  4'b0001, 4'd2}, // R2 store uses add
      '{3'd4, 1'b1, 6'd42, 2'b11, 6'd44, 6'd46, 8'd0,  4'b0000, 4'd5}, // R5 first divide
      '{3'd4, 1'b1, 6'd48, 2'b11, 6'd50, 6'd52, 8'd24, 4'b0100, 4'd5}, // R5 second divide
      '{3'd2, 1'b1, 6'd48, 2'b11, 6'd33, 6'd35, 8'd25, 4'b0010, 4'd6}, // R6 WAW on divide
      '{3'd3, 1'b1, 6'd54, 2'b11, 6'd56, 6'd58, 8'd0,  4'b0000, 4'd7}, // R7 mul
      '{3'd2, 1'b1, 6'd60, 2'b11, 6'd33, 6'd35, 8'd0,  4'b0000, 4'd7}, // R7 add next cycle
      '{3'd1, 1'b1, 6'd62, 2'b01, 6'd5,  6'd0,  8'd1,  4'b1000, 4'd4}, // R4 load hits add WB
      '{3'd0, 1'b1, 6'd7,  2'b11, 6'd1,  6'd2,  8'd1,  4'b1000, 4'd4}, // R4 int hits add WB
      '{3'd0, 1'b1, 6'd8,  2'b11, 6'd7,  6'd9,  8'd1,  4'b1000, 4'd4}, // R4 int hits mul WB
      '{3'd0, 1'b1, 6'd10, 2'b11, 6'd8,  6'd1,  8'd0,  4'b0000, 4'd2}, // R2 int forward
      '{3'd2, 1'b1, 6'd34, 2'b11, 6'd62, 6'd36, 8'd0,  4'b0000, 4'd2}, // R2 load done
      '{3'd3, 1'b1, 6'd37, 2'b11, 6'd33, 6'd33, 8'd0,  4'b0000, 4'd3}, // R3 mul F5
      '{3'd0, 1'b1, 6'd6,  2'b11, 6'd5,  6'd5,  8'd0,  4'b0000, 4'd3}, // R3 int R5 free
      '{3'd2, 1'b1, 6'd39, 2'b11, 6'd37, 6'd33, 8'd5,  4'b0001, 4'd2}  // R2 add waits F5
   };

   function automatic logic [3:0] flags();
      return {stall_port, stall_div, stall_waw, stall_raw};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      id_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive(input vec_t v);
      id_valid  = 1'b1;
      id_unit   = v.unit;
      id_dst_en = v.den;
      id_dst    = v.dst;
      id_src_en = v.sen;
      id_src_a  = v.sa;
      id_src_b  = v.sb;
   endtask

   task automatic present(input vec_t v, input int idx);
      int stalls = 0;
      logic [3:0] first = '0;
      bit got = 0;
      string rq;
      rq = $sformatf("R%0d", v.req);
      @(negedge clk);
      drive(v);
      #1;
      while (!issue && stalls < 300) begin
         if (!got) begin first = flags(); got = 1; end
         stalls++;
         @(negedge clk);
         #1;
      end
      chk(stalls == int'(v.stl), rq, $sformatf("instr %0d stall cycles", idx),
          stalls, int'(v.stl));
      chk((got ? first : 4'b0000) == v.flg, rq,
          $sformatf("instr %0d first stall flags", idx),
          int'(got ? first : 4'b0000), int'(v.flg));
      // R8: at the issue cycle no stall flag is raised
      chk(flags() == 4'b0000, "R8", $sformatf("instr %0d flags at issue", idx),
          int'(flags()), 0);
   endtask

   localparam vec_t DIVA = '{3'd4, 1'b1, 6'd41, 2'b11, 6'd43, 6'd45, 8'd0, 4'b0000, 4'd5};
   localparam vec_t DIVB = '{3'd4, 1'b1, 6'd47, 2'b11, 6'd49, 6'd51, 8'd0, 4'b0000, 4'd5};

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R9: reset state, idle decode
      @(negedge clk); #1;
      chk(issue == 1'b0 && flags() == 4'b0000, "R9", "reset outputs idle",
          int'({issue, flags()}), 0);

      // R1: divide fields presented with valid low for three edges
      drive(DIVA);
      id_valid = 1'b0;
      repeat (3) begin
         @(negedge clk); #1;
         chk(issue == 1'b0 && flags() == 4'b0000, "R1", "idle decode quiet",
             int'({issue, flags()}), 0);
      end
      // R1: the idle cycles left no trace, divide goes at once
      id_valid = 1'b1;
      #1;
      chk(issue == 1'b1, "R1", "divide after idle issues", int'(issue), 1);
      // R5: next divide is refused by the busy divider
      @(negedge clk);
      drive(DIVB);
      #1;
      chk(stall_div == 1'b1 && issue == 1'b0, "R5", "divide while busy",
          int'({issue, stall_div}), 1);
      // R9: reset clears the divider countdown
      do_reset();
      drive(DIVB);
      #1;
      chk(issue == 1'b1 && stall_div == 1'b0, "R9", "divide after reset",
          int'({issue, stall_div}), 2);

      do_reset();
      for (int i = 0; i < NV; i++) present(TBL[i], i);
      @(negedge clk);
      id_valid = 1'b0;
      #1;
      chk(issue == 1'b0, "R1", "valid dropped", int'(issue), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule